// File: doc/BRIEF.md
# Counter Channel Byte Command Port

This block is the host-side register logic for a single up/down counter channel. The host sees two 8-bit ports. The even port (address 0) carries data and the odd port (address 1) carries control and status. A control write is routed by its bits 6:5 to one of four targets:

- a reset/load command decoder;
- a counter mode register;
- an input control register;
- an index control register.

The counter itself sits outside the block. The block drives its configuration, a preset value, a prescaler value and single-cycle command pulses. It takes back the live count and two status flags.

The 24-bit preset register and the 24-bit output latch are reached one byte at a time through a shared byte pointer. The pointer advances after each data-port access and can be cleared by a command. Commands can copy the preset into the counter, snapshot the counter into the output latch, or copy the preset low byte into the filter prescaler.

Top module: `cnt_cmd_if`

## Requirements
- R1: After reset, every configuration output, `preset_o`, `psc_o`, the output latch, the byte pointer and every command pulse are zero. This gives binary counting, normal count mode, non-quadrature counting, inputs disabled and negative index polarity.
- R2: A control write selects its target from bits 6:5: 00 = command, 01 = mode, 10 = input control, 11 = index control. Only the selected target changes.
  - Mode register: bit 0 drives `bcd_o`, bits 2:1 drive `count_mode_o`, bits 4:3 drive `quad_mode_o` (00 none, 01 x1, 10 x2, 11 x4).
  - Input control register: bit 0 drives `ab_en_o`, bit 1 drives `idx_load_n_o`.
  - Index control register: bit 0 drives `idx_sync_o`, bit 1 drives `idx_pol_o`.
  - Each register output holds its new value from the clock edge after the write.
- R3: Data-port writes fill the preset register least significant byte first. The pointer advances by one after each write and returns to byte 0 after byte 2.
- R4: A data-port read returns the output latch byte selected by the pointer, least significant byte first. The value appears on `rdata_o` in the cycle after the read strobe, and the pointer then advances with the same wrap as in R3.
- R5: A command write with bit 0 set returns the byte pointer to byte 0.
- R6: Command bits 2:1 request a clear:
  - 01 pulses `clr_cnt_o`;
  - 10 pulses `clr_flags_o`;
  - 11 pulses `clr_err_o`.

  The pulse lasts one cycle and falls in the cycle after the write. No other clear pulse is raised.
- R7: Command bits 4:3 request a transfer:
  - 01 pulses `load_cnt_o` for one cycle, the cycle after the write, with the preset on `preset_o`;
  - 10 copies `cnt_i` into the output latch at the write edge;
  - 11 copies the preset low byte into `psc_o`.
- R8: A pointer reset and a transfer in the same command write both take effect. The following data reads start at byte 0 of the newly captured latch.
- R9: A control-port read returns the status byte in the cycle after the strobe: `err_flag_i` in bit 4, `up_flag_i` in bit 5, all other bits zero. It does not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 1 | 0 = data port, 1 = control/status port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| cnt_i | input | 24 | Live counter value from the core |
| err_flag_i | input | 1 | Noise error flag from the core |
| up_flag_i | input | 1 | Count direction flag from the core, 1 = up |
| preset_o | output | 24 | Preset register |
| load_cnt_o | output | 1 | Pulse: load preset into the counter |
| clr_cnt_o | output | 1 | Pulse: clear the counter |
| clr_flags_o | output | 1 | Pulse: clear borrow/carry/compare/sign flags |
| clr_err_o | output | 1 | Pulse: clear the error flag |
| psc_o | output | 8 | Filter clock prescaler |
| bcd_o | output | 1 | Mode bit 0 (0 = binary) |
| count_mode_o | output | 2 | Count mode |
| quad_mode_o | output | 2 | Quadrature scaling select |
| ab_en_o | output | 1 | A/B input enable |
| idx_load_n_o | output | 1 | Preset-on-index enable, active low |
| idx_sync_o | output | 1 | Synchronous index mode |
| idx_pol_o | output | 1 | Index polarity, 1 = positive |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it:
- configuration outputs, preset bytes, prescaler and latch contents settle at the edge that captures the write;
- command pulses are high only during the following cycle;
- read data is registered at the read edge.

The bench drives strobes on the falling edge and holds them for one full cycle. Pulses and register outputs are checked at the next falling edge. Each read pushes its expected byte into a queue, and a monitor pops and compares it at the falling edge after the capture edge.

Pointer behaviour is observed only through the data the port returns.

// File: rtl/cnt_cmd_if_pkg.sv
package cnt_cmd_if_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned STAT_ERR_BIT = 4;
  localparam int unsigned STAT_UP_BIT = 5;

  typedef enum logic [1:0] {
    TGT_CMD  = 2'b00,
    TGT_MODE = 2'b01,
    TGT_IO   = 2'b10,
    TGT_IDX  = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_CNT   = 2'b01,
    CLR_FLAGS = 2'b10,
    CLR_ERR   = 2'b11
  } clr_e;

  typedef enum logic [1:0] {
    XF_NONE  = 2'b00,
    XF_LOAD  = 2'b01,
    XF_LATCH = 2'b10,
    XF_PSC   = 2'b11
  } xfer_e;

  typedef struct packed {
    logic  valid;
    logic  ptr_rst;
    clr_e  clr;
    xfer_e xfer;
  } cmd_t;

  typedef struct packed {
    logic       bcd;
    logic [1:0] count_mode;
    logic [1:0] quad_mode;
    logic       ab_en;
    logic       idx_load_n;
    logic       idx_sync;
    logic       idx_pol;
  } cfg_t;
endpackage

// File: rtl/cnt_ctl_decode.sv
module cnt_ctl_decode
  import cnt_cmd_if_pkg::*;
(
  input  logic              ctl_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output cmd_t              cmd_o,
  output logic              we_mode_o,
  output logic              we_io_o,
  output logic              we_idx_o
);
  tgt_e tgt;

  always_comb begin
    tgt = tgt_e'(wdata_i[6:5]);
    cmd_o.valid   = ctl_wr_i && (tgt == TGT_CMD);
    cmd_o.ptr_rst = wdata_i[0];
    cmd_o.clr     = clr_e'(wdata_i[2:1]);
    cmd_o.xfer    = xfer_e'(wdata_i[4:3]);
    we_mode_o     = ctl_wr_i && (tgt == TGT_MODE);
    we_io_o       = ctl_wr_i && (tgt == TGT_IO);
    we_idx_o      = ctl_wr_i && (tgt == TGT_IDX);
  end
endmodule

// File: rtl/cnt_byte_ptr.sv
module cnt_byte_ptr #(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (clr_i) begin
      ptr_o <= '0;
    end else if (adv_i) begin
      ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/cnt_data_regs.sv
module cnt_data_regs
  import cnt_cmd_if_pkg::*;
#(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned CW = NBYTES * BYTE_W,
  localparam int unsigned PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              latch_i,
  input  logic              psc_ld_i,
  input  logic [CW-1:0]     cnt_i,
  output logic [CW-1:0]     preset_o,
  output logic [BYTE_W-1:0] latch_byte_o,
  output logic [BYTE_W-1:0] psc_o
);
  logic [CW-1:0] latch_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        preset_o[b*BYTE_W +: BYTE_W] <= '0;
      end else if (data_wr_i && (ptr_i == PTR_W'(b))) begin
        preset_o[b*BYTE_W +: BYTE_W] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      psc_o   <= '0;
    end else begin
      if (latch_i)  latch_q <= cnt_i;
      if (psc_ld_i) psc_o   <= preset_o[BYTE_W-1:0];
    end
  end

  always_comb begin
    latch_byte_o = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (ptr_i == PTR_W'(b)) latch_byte_o = latch_q[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/cnt_cfg_regs.sv
module cnt_cfg_regs
  import cnt_cmd_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_mode_i,
  input  logic              we_io_i,
  input  logic              we_idx_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output cfg_t              cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else begin
      if (we_mode_i) begin
        cfg_o.bcd        <= wdata_i[0];
        cfg_o.count_mode <= wdata_i[2:1];
        cfg_o.quad_mode  <= wdata_i[4:3];
      end
      if (we_io_i) begin
        cfg_o.ab_en      <= wdata_i[0];
        cfg_o.idx_load_n <= wdata_i[1];
      end
      if (we_idx_i) begin
        cfg_o.idx_sync   <= wdata_i[0];
        cfg_o.idx_pol    <= wdata_i[1];
      end
    end
  end
endmodule

// File: rtl/cnt_cmd_if.sv
module cnt_cmd_if
  import cnt_cmd_if_pkg::*;
#(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned CW = NBYTES * BYTE_W,
  localparam int unsigned PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [CW-1:0]     cnt_i,
  input  logic              err_flag_i,
  input  logic              up_flag_i,
  output logic [CW-1:0]     preset_o,
  output logic              load_cnt_o,
  output logic              clr_cnt_o,
  output logic              clr_flags_o,
  output logic              clr_err_o,
  output logic [BYTE_W-1:0] psc_o,
  output logic              bcd_o,
  output logic [1:0]        count_mode_o,
  output logic [1:0]        quad_mode_o,
  output logic              ab_en_o,
  output logic              idx_load_n_o,
  output logic              idx_sync_o,
  output logic              idx_pol_o
);
  cmd_t              cmd;
  cfg_t              cfg;
  logic              we_mode, we_io, we_idx;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] latch_byte;
  logic              data_wr, data_rd, stat_rd;

  assign data_wr = wr_i && !addr_i;
  assign data_rd = rd_i && !addr_i;
  assign stat_rd = rd_i && addr_i;

  cnt_ctl_decode u_dec (
    .ctl_wr_i  (wr_i && addr_i),
    .wdata_i   (wdata_i),
    .cmd_o     (cmd),
    .we_mode_o (we_mode),
    .we_io_o   (we_io),
    .we_idx_o  (we_idx)
  );

  cnt_byte_ptr #(.NBYTES(NBYTES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd.valid && cmd.ptr_rst),
    .adv_i  (data_wr || data_rd),
    .ptr_o  (ptr)
  );

  cnt_data_regs #(.NBYTES(NBYTES)) u_data (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_wr_i    (data_wr),
    .ptr_i        (ptr),
    .wdata_i      (wdata_i),
    .latch_i      (cmd.valid && (cmd.xfer == XF_LATCH)),
    .psc_ld_i     (cmd.valid && (cmd.xfer == XF_PSC)),
    .cnt_i        (cnt_i),
    .preset_o     (preset_o),
    .latch_byte_o (latch_byte),
    .psc_o        (psc_o)
  );

  cnt_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_mode_i (we_mode),
    .we_io_i   (we_io),
    .we_idx_i  (we_idx),
    .wdata_i   (wdata_i),
    .cfg_o     (cfg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_cnt_o  <= 1'b0;
      clr_cnt_o   <= 1'b0;
      clr_flags_o <= 1'b0;
      clr_err_o   <= 1'b0;
    end else begin
      load_cnt_o  <= cmd.valid && (cmd.xfer == XF_LOAD);
      clr_cnt_o   <= cmd.valid && (cmd.clr == CLR_CNT);
      clr_flags_o <= cmd.valid && (cmd.clr == CLR_FLAGS);
      clr_err_o   <= cmd.valid && (cmd.clr == CLR_ERR);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (stat_rd) begin
      rdata_o <= '0;
      rdata_o[STAT_ERR_BIT] <= err_flag_i;
      rdata_o[STAT_UP_BIT]  <= up_flag_i;
    end else if (data_rd) begin
      rdata_o <= latch_byte;
    end
  end

  assign bcd_o        = cfg.bcd;
  assign count_mode_o = cfg.count_mode;
  assign quad_mode_o  = cfg.quad_mode;
  assign ab_en_o      = cfg.ab_en;
  assign idx_load_n_o = cfg.idx_load_n;
  assign idx_sync_o   = cfg.idx_sync;
  assign idx_pol_o    = cfg.idx_pol;
endmodule

// File: rtl/cnt_cmd_if_chk.sv
module cnt_cmd_if_chk #(
  parameter int unsigned PTR_W = 2,
  parameter int unsigned NBYTES = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic             addr_i,
  input logic [7:0]       wdata_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic             load_cnt_o,
  input logic             clr_cnt_o,
  input logic             clr_flags_o,
  input logic             clr_err_o,
  input logic             ab_en_o,
  input logic             idx_pol_o
);
  // R6: a clear pulse only follows a matching command write
  a_r6_clr_cnt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cnt_o |-> $past(wr_i && addr_i && wdata_i[6:5] == 2'b00 && wdata_i[2:1] == 2'b01));

  // R6: at most one clear pulse at a time
  a_r6_one_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_cnt_o, clr_flags_o, clr_err_o}));

  // R7: load pulse only follows a load command
  a_r7_load_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_cnt_o |-> $past(wr_i && addr_i && wdata_i[6:5] == 2'b00 && wdata_i[4:3] == 2'b01));

  // R9: status read leaves the pointer alone
  a_r9_status_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i && !wr_i) |=> ptr_i == $past(ptr_i));

  // R3: pointer stays within the byte range
  a_r3_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_i < PTR_W'(NBYTES));

  // R2: config outputs change only on a control write
  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i) |=> $stable(ab_en_o) && $stable(idx_pol_o));
endmodule

bind cnt_cmd_if cnt_cmd_if_chk #(.PTR_W(PTR_W), .NBYTES(NBYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .ptr_i       (ptr),
  .load_cnt_o  (load_cnt_o),
  .clr_cnt_o   (clr_cnt_o),
  .clr_flags_o (clr_flags_o),
  .clr_err_o   (clr_err_o),
  .ab_en_o     (ab_en_o),
  .idx_pol_o   (idx_pol_o)
);

// File: tb/cnt_cmd_if_bench.sv
module cnt_cmd_if_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [23:0] cnt_i = '0;
  logic        err_flag_i = 1'b0, up_flag_i = 1'b0;
  logic [23:0] preset_o;
  logic        load_cnt_o, clr_cnt_o, clr_flags_o, clr_err_o;
  logic [7:0]  psc_o;
  logic        bcd_o, ab_en_o, idx_load_n_o, idx_sync_o, idx_pol_o;
  logic [1:0]  count_mode_o, quad_mode_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cnt_cmd_if u_cnt_cmd_if (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_i(cnt_i),
    .err_flag_i(err_flag_i), .up_flag_i(up_flag_i), .preset_o(preset_o),
    .load_cnt_o(load_cnt_o), .clr_cnt_o(clr_cnt_o), .clr_flags_o(clr_flags_o),
    .clr_err_o(clr_err_o), .psc_o(psc_o), .bcd_o(bcd_o),
    .count_mode_o(count_mode_o), .quad_mode_o(quad_mode_o), .ab_en_o(ab_en_o),
    .idx_load_n_o(idx_load_n_o), .idx_sync_o(idx_sync_o), .idx_pol_o(idx_pol_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  // monitor: a read captured at posedge is compared at the next negedge
  always @(posedge clk) rd_seen <= rd_i;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4: actual %0h expected none", rdata_o);
      end else begin
        check(tag_q.pop_front(), {24'd0, rdata_o}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {bcd_o, count_mode_o, quad_mode_o, ab_en_o, idx_load_n_o, idx_sync_o, idx_pol_o}, 0);
    check("R1", {preset_o, psc_o}, 0);
    check("R1", {load_cnt_o, clr_cnt_o, clr_flags_o, clr_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(1'b0, 8'h00, "R1 latch");

    // R2 mode register: bcd=1, count_mode=01, quad=11
    wr(1'b1, 8'h3B);
    check("R2 mode", {bcd_o, count_mode_o, quad_mode_o}, 5'b1_01_11);
    check("R2 other", {ab_en_o, idx_load_n_o, idx_sync_o, idx_pol_o}, 0);
    wr(1'b1, 8'h43);
    check("R2 io", {ab_en_o, idx_load_n_o}, 2'b11);
    check("R2 mode kept", {bcd_o, count_mode_o, quad_mode_o}, 5'b1_01_11);
    wr(1'b1, 8'h62);
    check("R2 idx", {idx_sync_o, idx_pol_o}, 2'b01);
    check("R2 io kept", {ab_en_o, idx_load_n_o}, 2'b11);

    // R5/R3 preset fill, LSB first, wrap
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h11); wr(1'b0, 8'h22); wr(1'b0, 8'h33);
    check("R3 fill", preset_o, 24'h332211);
    wr(1'b0, 8'h44);
    check("R3 wrap", preset_o, 24'h332244);
    wr(1'b0, 8'h66);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h55);
    check("R5 ptr reset", preset_o, 24'h336655);

    // R7 load pulse
    wr(1'b1, 8'h08);
    check("R7 load", {load_cnt_o, preset_o}, {1'b1, 24'h336655});
    @(negedge clk);
    check("R7 load one cycle", load_cnt_o, 0);

    // R6 clears
    wr(1'b1, 8'h02);
    check("R6 clr_cnt", {clr_cnt_o, clr_flags_o, clr_err_o}, 3'b100);
    wr(1'b1, 8'h04);
    check("R6 clr_flags", {clr_cnt_o, clr_flags_o, clr_err_o}, 3'b010);
    wr(1'b1, 8'h06);
    check("R6 clr_err", {clr_cnt_o, clr_flags_o, clr_err_o}, 3'b001);
    @(negedge clk);
    check("R6 idle", {clr_cnt_o, clr_flags_o, clr_err_o, load_cnt_o}, 0);

    // R7 prescaler copy
    wr(1'b1, 8'h18);
    check("R7 psc", psc_o, 8'h55);

    // R8 pointer reset with latch; pointer first moved off byte 0
    cnt_i = 24'hABCDEF;
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h10);
    rd(1'b0, 8'hEF, "R4 latch byte0");
    wr(1'b1, 8'h11);
    cnt_i = 24'h123456;
    rd(1'b0, 8'hEF, "R8 byte0");
    rd(1'b0, 8'hCD, "R4 byte1");
    rd(1'b0, 8'hAB, "R4 byte2");
    rd(1'b0, 8'hEF, "R4 wrap");

    // R9 status and pointer hold
    err_flag_i = 1'b1; up_flag_i = 1'b0;
    rd(1'b1, 8'h10, "R9 err");
    err_flag_i = 1'b0; up_flag_i = 1'b1;
    rd(1'b1, 8'h20, "R9 up");
    rd(1'b0, 8'hCD, "R9 ptr held");

    repeat (3) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule